// File: doc/BRIEF.md
# Boot Ratchet Memory Access Controller

This block decides, for every request on a small memory bus, whether the code running at the current boot stage may touch the addressed word. A hardware reset sets a privilege ratchet to its most privileged value, zero, so that the permanent boot code always runs first. Each later boot stage pulses an advance strobe before handing control onward. The ratchet then climbs one step at a time and cannot come back down until the next reset. Four code layers exist: 0 is the boot ROM, 1 the updatable boot loader, 2 the operating system and 3 the application. The controller holds two memories. The first is a battery-backed secure memory with one page per layer. The second is a rewritable code store with one region per layer.

A tamper input wipes the secure memory. A counter walks every secure word and writes zero to it, while a busy output is high and every request is refused. The code store keeps its contents. A sticky tamper flag records the event. An ordinary reset does not clear the flag. Only a factory-clear strobe clears it, and only while the ratchet is zero. A separate power-on reset covers the battery domain: it clears the tamper flag and the sweep state. The ordinary reset only resets the ratchet and the response path.

Top module: `boot_ratchet_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the ratchet level (`level_o`) becomes 0 at that edge, and the response outputs go inactive.
- R2: A pulse on `adv_i` raises the level by exactly one, and the level saturates at 3. No input other than `rst_n` can lower it.
- R3: Secure page N covers word addresses `8*N` to `8*N+7`. A read or write to page N is granted only while the level is N or lower.
- R4: Code region N covers word addresses `0x80+16*N` to `0x80+16*N+15`. Reads of any region are granted at every level. Writes are granted only while the level is 0 or 1.
- R5: A denied request answers with `resp_err_o`=1, `resp_grant_o`=0 and `resp_rdata_o`=0, and it leaves both memories unchanged. An address outside every page and region is always denied.
- R6: A request presented at one clock edge is answered with `resp_valid_o`=1 just after that edge. A granted read returns the stored word.
- R7: A tamper pulse sets every secure-memory word to zero. All code-store words keep their values.
- R8: `zeroize_o` rises at the edge that samples `tamper_i` and stays high for exactly 32 cycles, one per secure word. A request is denied while `zeroize_o` or `tamper_i` is high.
- R9: `tamper_flag_o` is set by a tamper pulse and stays set across `rst_n` resets. Only `fact_clr_i` clears it, and only while the level is 0 and no sweep is running.
- R10: A sweep that has started runs to completion even if `rst_n` is asserted during it. Only `por_n` aborts the sweep and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of ratchet and response path |
| por_n | input | 1 | Synchronous active-low power-on reset of the battery domain |
| adv_i | input | 1 | Ratchet advance strobe |
| tamper_i | input | 1 | Synchronised tamper detect |
| fact_clr_i | input | 1 | Factory-initialisation strobe that clears the tamper flag |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Word address |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Response present |
| resp_grant_o | output | 1 | Request was allowed |
| resp_err_o | output | 1 | Request was denied |
| resp_rdata_o | output | 32 | Read data, zero when denied |
| zeroize_o | output | 1 | Secure-memory sweep in progress |
| tamper_flag_o | output | 1 | Sticky tamper indication |
| level_o | output | 2 | Current ratchet level |

## Verification
A wrong ratchet value shows up on `level_o` at once, and in the grant of the very next request to a page boundary layer. That is why each level is visited and every page is probed from every level. A corrupted sweep counter shows up in the length of `zeroize_o` and later as non-zero secure data read after the sweep. Any write that slips through at a denied level is exposed by reading the word back after a reset drops the level to 0.

// File: rtl/brc_pkg.sv
// Package: shared types of the boot ratchet controller.
// Assumes: nothing beyond the standard.
package brc_pkg;
    // Kind of region an address falls in.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_SEC  = 2'd1,
        RGN_CODE = 2'd2
    } region_e;
endpackage

// File: rtl/brc_ratchet.sv
// Module: brc_ratchet
// Holds the monotonic privilege level. Reset forces zero, an advance strobe
// adds one, and the level saturates at LAYERS-1.
// Assumes: adv_i is a single-cycle, synchronous strobe.
module brc_ratchet #(
    parameter int LAYERS = 4,
    localparam int LVL_W = $clog2(LAYERS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [LVL_W-1:0] level_o
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(LAYERS - 1);

    // Level register: only reset lowers it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_o <= '0;
        else if (adv_i && level_o != TOP)
            level_o <= level_o + 1'b1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> level_o == '0); // R1
    AST_NEVER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level_o >= $past(level_o)); // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(level_o)); // R2
endmodule

// File: rtl/brc_decode.sv
// Module: brc_decode
// Maps a word address to a secure page or a code region, and gives the
// owning layer and the word index within that memory.
// Assumes: pages and regions are contiguous and do not overlap.
module brc_decode
    import brc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int LAYERS       = 4,
    parameter int SEC_BASE     = 0,
    parameter int PAGE_WORDS   = 8,
    parameter int CODE_BASE    = 128,
    parameter int REGION_WORDS = 16,
    localparam int LVL_W   = $clog2(LAYERS),
    localparam int SEC_IW  = $clog2(LAYERS * PAGE_WORDS),
    localparam int CODE_IW = $clog2(LAYERS * REGION_WORDS)
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output region_e            kind_o,
    output logic [LVL_W-1:0]   layer_o,
    output logic [SEC_IW-1:0]  sec_idx_o,
    output logic [CODE_IW-1:0] code_idx_o
);
    logic [31:0] a;

    // Range compare against every page and region.
    always_comb begin
        a          = 32'(addr_i);
        kind_o     = RGN_NONE;
        layer_o    = '0;
        for (int l = 0; l < LAYERS; l++) begin
            if (a >= 32'(SEC_BASE + l * PAGE_WORDS) &&
                a <  32'(SEC_BASE + (l + 1) * PAGE_WORDS)) begin
                kind_o  = RGN_SEC;
                layer_o = LVL_W'(l);
            end
            if (a >= 32'(CODE_BASE + l * REGION_WORDS) &&
                a <  32'(CODE_BASE + (l + 1) * REGION_WORDS)) begin
                kind_o  = RGN_CODE;
                layer_o = LVL_W'(l);
            end
        end
        sec_idx_o  = SEC_IW'(a - 32'(SEC_BASE));
        code_idx_o = CODE_IW'(a - 32'(CODE_BASE));
    end
endmodule

// File: rtl/brc_policy.sv
// Module: brc_policy
// Grants or denies one request from its region, owning layer, direction
// and the current level. Everything is refused during a sweep or tamper.
// Assumes: decode outputs are valid in the same cycle.
module brc_policy
    import brc_pkg::*;
#(
    parameter int LAYERS      = 4,
    parameter int CODE_WR_MAX = 1,
    localparam int LVL_W = $clog2(LAYERS)
) (
    input  region_e          kind_i,
    input  logic [LVL_W-1:0] layer_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             write_i,
    input  logic             busy_i,
    input  logic             tamper_i,
    output logic             grant_o
);
    localparam logic [LVL_W-1:0] WR_LIM = LVL_W'(CODE_WR_MAX);

    // Access rule per region kind.
    always_comb begin
        unique case (kind_i)
            RGN_SEC:  grant_o = (layer_i >= level_i);
            RGN_CODE: grant_o = !write_i || (level_i <= WR_LIM);
            default:  grant_o = 1'b0;
        endcase
        if (busy_i || tamper_i)
            grant_o = 1'b0;
    end
endmodule

// File: rtl/brc_zeroize.sv
// Module: brc_zeroize
// Sweeps every secure word to zero after tamper and keeps the sticky flag.
// Lives in the battery domain: only por_n resets it.
// Assumes: tamper_i is already synchronised to clk.
module brc_zeroize #(
    parameter int SEC_WORDS = 32,
    localparam int SEC_IW = $clog2(SEC_WORDS)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tamper_i,
    input  logic              fact_clr_i,
    input  logic              clr_ok_i,
    output logic              busy_o,
    output logic [SEC_IW-1:0] idx_o,
    output logic              flag_o
);
    localparam logic [SEC_IW-1:0] LAST = SEC_IW'(SEC_WORDS - 1);

    // Sweep counter: restarts on every tamper sample.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            busy_o <= 1'b0;
            idx_o  <= '0;
        end else if (tamper_i) begin
            busy_o <= 1'b1;
            idx_o  <= '0;
        end else if (busy_o) begin
            if (idx_o == LAST)
                busy_o <= 1'b0;
            else
                idx_o <= idx_o + 1'b1;
        end
    end

    // Sticky tamper flag.
    always_ff @(posedge clk) begin
        if (!por_n)
            flag_o <= 1'b0;
        else if (tamper_i)
            flag_o <= 1'b1;
        else if (fact_clr_i && clr_ok_i && !busy_o)
            flag_o <= 1'b0;
    end

    AST_TAMPER_ARMS: assert property (@(posedge clk) disable iff (!por_n)
        tamper_i |=> busy_o && flag_o && idx_o == '0); // R7
    AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        busy_o && idx_o != LAST |=> busy_o); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        flag_o && !fact_clr_i |=> flag_o); // R9
endmodule

// File: rtl/boot_ratchet_ctrl.sv
// Module: boot_ratchet_ctrl (top)
// Gates secure-page and code-store access by a boot privilege ratchet and
// wipes the secure memory on tamper. Responses are registered, one cycle
// after the request.
// Assumes: secure and code memories power up undefined; software writes
// before reading. All inputs are synchronous to clk.
module boot_ratchet_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int LAYERS       = 4,
    parameter int SEC_BASE     = 0,
    parameter int PAGE_WORDS   = 8,
    parameter int CODE_BASE    = 128,
    parameter int REGION_WORDS = 16,
    parameter int CODE_WR_MAX  = 1,
    localparam int LVL_W      = $clog2(LAYERS),
    localparam int SEC_WORDS  = LAYERS * PAGE_WORDS,
    localparam int CODE_WORDS = LAYERS * REGION_WORDS,
    localparam int SEC_IW     = $clog2(SEC_WORDS),
    localparam int CODE_IW    = $clog2(CODE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              adv_i,
    input  logic              tamper_i,
    input  logic              fact_clr_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              resp_valid_o,
    output logic              resp_grant_o,
    output logic              resp_err_o,
    output logic [DATA_W-1:0] resp_rdata_o,
    output logic              zeroize_o,
    output logic              tamper_flag_o,
    output logic [LVL_W-1:0]  level_o
);
    region_e            kind;
    logic [LVL_W-1:0]   layer;
    logic [SEC_IW-1:0]  sec_idx;
    logic [CODE_IW-1:0] code_idx;
    logic [SEC_IW-1:0]  wipe_idx;
    logic               grant;
    logic               sec_we;
    logic               code_we;

    logic [DATA_W-1:0] sec_mem  [SEC_WORDS];
    logic [DATA_W-1:0] code_mem [CODE_WORDS];

    brc_ratchet #(.LAYERS(LAYERS)) ratchet_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv_i),
        .level_o (level_o)
    );

    brc_decode #(
        .ADDR_W       (ADDR_W),
        .LAYERS       (LAYERS),
        .SEC_BASE     (SEC_BASE),
        .PAGE_WORDS   (PAGE_WORDS),
        .CODE_BASE    (CODE_BASE),
        .REGION_WORDS (REGION_WORDS)
    ) decode_i (
        .addr_i     (req_addr_i),
        .kind_o     (kind),
        .layer_o    (layer),
        .sec_idx_o  (sec_idx),
        .code_idx_o (code_idx)
    );

    brc_policy #(.LAYERS(LAYERS), .CODE_WR_MAX(CODE_WR_MAX)) policy_i (
        .kind_i   (kind),
        .layer_i  (layer),
        .level_i  (level_o),
        .write_i  (req_write_i),
        .busy_i   (zeroize_o),
        .tamper_i (tamper_i),
        .grant_o  (grant)
    );

    brc_zeroize #(.SEC_WORDS(SEC_WORDS)) zeroize_i (
        .clk        (clk),
        .por_n      (por_n),
        .tamper_i   (tamper_i),
        .fact_clr_i (fact_clr_i),
        .clr_ok_i   (level_o == '0),
        .busy_o     (zeroize_o),
        .idx_o      (wipe_idx),
        .flag_o     (tamper_flag_o)
    );

    assign sec_we  = req_valid_i && req_write_i && grant && kind == RGN_SEC;
    assign code_we = req_valid_i && req_write_i && grant && kind == RGN_CODE;

    // Secure memory: the sweep owns the write port while it runs.
    always_ff @(posedge clk) begin
        if (zeroize_o)
            sec_mem[wipe_idx] <= '0;
        else if (sec_we)
            sec_mem[sec_idx] <= req_wdata_i;
    end

    // Code store: granted writes only, never touched by the sweep.
    always_ff @(posedge clk) begin
        if (code_we)
            code_mem[code_idx] <= req_wdata_i;
    end

    // Registered response with zeroed data on deny.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_grant_o <= 1'b0;
            resp_err_o   <= 1'b0;
            resp_rdata_o <= '0;
        end else begin
            resp_valid_o <= req_valid_i;
            resp_grant_o <= req_valid_i && grant;
            resp_err_o   <= req_valid_i && !grant;
            if (req_valid_i && grant && !req_write_i)
                resp_rdata_o <= (kind == RGN_SEC) ? sec_mem[sec_idx] : code_mem[code_idx];
            else
                resp_rdata_o <= '0;
        end
    end

    AST_PAGE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && kind == RGN_SEC && layer < level_o |=> resp_err_o && !resp_grant_o); // R3
    AST_CODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_write_i && kind == RGN_CODE && level_o > LVL_W'(CODE_WR_MAX)
        |=> resp_err_o); // R4
    AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err_o |-> resp_rdata_o == '0 && !resp_grant_o); // R5
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> resp_valid_o); // R6
    AST_SWEEP_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && (zeroize_o || tamper_i) |=> resp_err_o); // R8
endmodule

// File: tb/boot_ratchet_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_ratchet_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        adv_i = 1'b0;
    logic        tamper_i = 1'b0;
    logic        fact_clr_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [7:0]  req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        resp_valid_o, resp_grant_o, resp_err_o;
    logic [31:0] resp_rdata_o;
    logic        zeroize_o, tamper_flag_o;
    logic [1:0]  level_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    boot_ratchet_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .adv_i(adv_i),
        .tamper_i(tamper_i), .fact_clr_i(fact_clr_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .resp_valid_o(resp_valid_o), .resp_grant_o(resp_grant_o),
        .resp_err_o(resp_err_o), .resp_rdata_o(resp_rdata_o),
        .zeroize_o(zeroize_o), .tamper_flag_o(tamper_flag_o), .level_o(level_o)
    );

    function automatic logic [31:0] pat(input logic [7:0] a);
        return 32'hA500_0000 | 32'(a);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                          output logic g, output logic [31:0] r);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_wdata_i = d;
        @(negedge clk);
        req_valid_i = 1'b0; req_write_i = 1'b0;
        g = resp_grant_o;
        r = resp_rdata_o;
        if (!resp_valid_o || resp_err_o === g) chk("R6 response handshake", {31'b0, g}, 32'hFFFF_FFFF);
    endtask

    task automatic advance();
        @(negedge clk); adv_i = 1'b1;
        @(negedge clk); adv_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic goto_level(input int lv);
        do_reset();
        for (int i = 0; i < lv; i++) advance();
    endtask

    task automatic t_reset();
        chk("R1 level after reset", 32'(level_o), 0);
        chk("R1 resp_valid after reset", 32'(resp_valid_o), 0);
        chk("R10 zeroize after power-on", 32'(zeroize_o), 0);
        chk("R9 flag after power-on", 32'(tamper_flag_o), 0);
    endtask

    task automatic t_ratchet();
        do_reset();
        for (int i = 1; i <= 5; i++) begin
            advance();
            chk("R2 level after advance", 32'(level_o), (i > 3) ? 3 : i);
        end
        repeat (3) @(negedge clk);
        chk("R2 level holds without strobe", 32'(level_o), 3);
        do_reset();
        chk("R1 reset lowers level", 32'(level_o), 0);
    endtask

    task automatic t_pages();
        logic g; logic [31:0] r;
        goto_level(0);
        for (int n = 0; n < 4; n++) begin
            access(1'b1, 8'(8*n), pat(8'(8*n)), g, r);
            chk("R3 page write at level 0", 32'(g), 1);
            access(1'b1, 8'(8*n+7), pat(8'(8*n+7)), g, r);
        end
        for (int lv = 0; lv < 4; lv++) begin
            goto_level(lv);
            chk("R2 level reached", 32'(level_o), 32'(lv));
            for (int n = 0; n < 4; n++) begin
                access(1'b0, 8'(8*n), 32'h0, g, r);
                chk("R3 page read grant", 32'(g), (n >= lv) ? 1 : 0);
                chk("R5 page read data", r, (n >= lv) ? pat(8'(8*n)) : 32'h0);
                if (n < lv) begin
                    access(1'b1, 8'(8*n+7), 32'hDEAD_BEEF, g, r);
                    chk("R3 page write denied", 32'(g), 0);
                end
            end
        end
        goto_level(0);
        for (int n = 0; n < 4; n++) begin
            access(1'b0, 8'(8*n+7), 32'h0, g, r);
            chk("R5 denied write left page intact", r, pat(8'(8*n+7)));
        end
    endtask

    task automatic t_code();
        logic g; logic [31:0] r;
        goto_level(0);
        for (int n = 0; n < 4; n++) begin
            access(1'b1, 8'(128+16*n), pat(8'(128+16*n)), g, r);
            chk("R4 code write at level 0", 32'(g), 1);
        end
        goto_level(1);
        access(1'b1, 8'(160), 32'h1234_5678, g, r);
        chk("R4 code write at level 1", 32'(g), 1);
        goto_level(2);
        access(1'b1, 8'(176), 32'hBAD0_0000, g, r);
        chk("R4 code write at level 2 denied", 32'(g), 0);
        goto_level(3);
        access(1'b0, 8'(176), 32'h0, g, r);
        chk("R4 code read at level 3", r, pat(8'd176));
        access(1'b0, 8'(160), 32'h0, g, r);
        chk("R6 read returns stored word", r, 32'h1234_5678);
        goto_level(0);
        access(1'b1, 8'h40, 32'hFFFF_FFFF, g, r);
        chk("R5 unmapped write denied", 32'(g), 0);
        access(1'b0, 8'h40, 32'h0, g, r);
        chk("R5 unmapped read denied", 32'(g), 0);
        chk("R5 unmapped read zero", r, 0);
    endtask

    task automatic t_tamper();
        logic g; logic [31:0] r;
        int busy;
        goto_level(2);
        @(negedge clk); tamper_i = 1'b1;
        @(negedge clk); tamper_i = 1'b0;
        busy = 0;
        while (zeroize_o && busy < 100) begin
            busy++;
            @(negedge clk);
        end
        chk("R8 sweep length", 32'(busy), 32);
        chk("R7 flag set", 32'(tamper_flag_o), 1);
        do_reset();
        chk("R9 flag survives reset", 32'(tamper_flag_o), 1);
        for (int w = 0; w < 32; w += 7) begin
            access(1'b0, 8'(w), 32'h0, g, r);
            chk("R7 secure word wiped", r, 0);
        end
        access(1'b0, 8'(128), 32'h0, g, r);
        chk("R7 code kept", r, pat(8'd128));
        access(1'b0, 8'(160), 32'h0, g, r);
        chk("R7 code kept", r, 32'h1234_5678);
    endtask

    task automatic t_sticky();
        goto_level(1);
        @(negedge clk); fact_clr_i = 1'b1;
        @(negedge clk); fact_clr_i = 1'b0;
        chk("R9 clear ignored at level 1", 32'(tamper_flag_o), 1);
        do_reset();
        @(negedge clk); fact_clr_i = 1'b1;
        @(negedge clk); fact_clr_i = 1'b0;
        chk("R9 clear honoured at level 0", 32'(tamper_flag_o), 0);
    endtask

    task automatic t_mid_sweep();
        logic g; logic [31:0] r;
        int guard;
        goto_level(0);
        access(1'b1, 8'd3, 32'h5555_AAAA, g, r);
        @(negedge clk); tamper_i = 1'b1;
        req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 8'd3;
        @(negedge clk); tamper_i = 1'b0; req_valid_i = 1'b0;
        chk("R8 request denied in tamper cycle", 32'(resp_grant_o), 0);
        access(1'b0, 8'h80, 32'h0, g, r);
        chk("R8 request denied during sweep", 32'(g), 0);
        do_reset();
        chk("R10 sweep survives reset", 32'(zeroize_o), 1);
        @(negedge clk); fact_clr_i = 1'b1;
        @(negedge clk); fact_clr_i = 1'b0;
        chk("R9 clear ignored during sweep", 32'(tamper_flag_o), 1);
        guard = 0;
        while (zeroize_o && guard < 100) begin guard++; @(negedge clk); end
        access(1'b0, 8'd3, 32'h0, g, r);
        chk("R10 word wiped after reset mid sweep", r, 0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R10 power-on clears flag", 32'(tamper_flag_o), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ratchet();
        t_pages();
        t_code();
        t_tamper();
        t_sticky();
        t_mid_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule